// File: doc/BRIEF.md
# Receive Character Queue with Line Status

This block sits between a serial deserializer and a processor bus. Each time the deserializer finishes a character it pulses a strobe carrying the byte and two error tags: a parity error and a missing stop bit. The block queues up to sixteen such characters. The byte and its two tags travel together through the queue.

The processor reads bytes through a registered read port. It sees four live status bits: data available, overrun, parity error and framing error. The two error bits always describe the character currently at the head of the queue, never one further back. An overrun is flagged at once when a character arrives while all sixteen slots are occupied. That character is thrown away and the stored ones are kept. A status read pulse acknowledges the three error bits. A flush input empties the queue in one cycle.

All outputs are registered. Every status bit reflects the queue state after the clock edge on which its cause was sampled.

Top module: `rx_fifo_lsr`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) leaves the queue empty and drives `rd_data`, `data_ready`, `overrun`, `parity_err` and `framing_err` to 0.
- R2: A `char_valid` pulse while fewer than DEPTH (16) characters are held stores `char_data`, `char_perr` and `char_ferr` as one entry. `data_ready` is 1 from the following cycle.
- R3: A `rd_data_en` pulse while the queue is not empty removes the oldest entry. Its byte appears on `rd_data` the next cycle, and entries leave in arrival order. A `rd_data_en` pulse on an empty queue changes nothing, and `rd_data` holds its last value.
- R4: A `char_valid` pulse while DEPTH entries are held sets `overrun` the next cycle. This holds even when a read happens in the same cycle. The arriving character is discarded and the stored entries are unchanged.
- R5: `parity_err` and `framing_err` equal the tags of the entry at the head of the queue. Tags of entries behind the head never show.
- R6: An `lsr_rd` pulse clears `overrun`, `parity_err` and `framing_err` on the next cycle. An overrun caused in the same cycle still sets `overrun`. A cleared head tag stays hidden until a different entry becomes the head.
- R7: When a different entry becomes the head, its own tags become visible, whether or not `lsr_rd` was pulsed earlier. This happens on a read, on a write into an empty queue, and when a read and an `lsr_rd` coincide.
- R8: A `fifo_flush` pulse empties the queue: `data_ready`, `parity_err` and `framing_err` go to 0 the next cycle. A character or read in the same cycle is ignored. `overrun` keeps its value.
- R9: `data_ready` is 0 whenever the queue holds no entry, including right after the last entry is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| char_valid | input | 1 | Character-complete strobe from the deserializer |
| char_data | input | DATA_W | Received byte |
| char_perr | input | 1 | Parity error tag of the received byte |
| char_ferr | input | 1 | Framing error tag of the received byte |
| fifo_flush | input | 1 | Empty the queue |
| rd_data_en | input | 1 | Read strobe for the head byte |
| rd_data | output | DATA_W | Last byte read, registered |
| lsr_rd | input | 1 | Status read strobe, acknowledges error bits |
| data_ready | output | 1 | Queue holds at least one entry |
| overrun | output | 1 | A character was lost to a full queue |
| parity_err | output | 1 | Head entry carries a parity error |
| framing_err | output | 1 | Head entry carries a framing error |

## Verification
The hardest cases to reach are those where several things happen in one cycle against a full queue. One is an arrival coinciding with a read while sixteen entries are held, which must still overrun. Another is a status read in the same cycle that the head moves on. To reach them, the stimulus fills the queue with long write bursts. It then drives reads, status reads and arrivals together, both in directed sequences and in biased random phases. A behavioural queue model is compared with every output on every cycle.

// File: rtl/rx_fifo_lsr_pkg.sv
package rx_fifo_lsr_pkg;
  typedef struct packed {
    logic perr;
    logic ferr;
  } rx_tag_t;
endpackage

// File: rtl/rxf_ctrl.sv
module rxf_ctrl #(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_req,
  input  logic             pop_req,
  input  logic             flush,
  output logic             push_ok,
  output logic             pop_ok,
  output logic             head_chg,
  output logic             ovr_hit,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [PTR_W-1:0] rd_ptr_n,
  output logic [CNT_W-1:0] fill,
  output logic [CNT_W-1:0] fill_n
);
  logic             full;
  logic             empty;
  logic [PTR_W-1:0] wr_ptr_n;

  always_comb begin
    full     = (fill == CNT_W'(DEPTH));
    empty    = (fill == '0);
    push_ok  = push_req && !flush && !full;
    pop_ok   = pop_req && !flush && !empty;
    ovr_hit  = push_req && !flush && full;
    head_chg = flush || pop_ok || (push_ok && empty);
    if (flush) begin
      rd_ptr_n = wr_ptr;
      wr_ptr_n = wr_ptr;
      fill_n   = '0;
    end else begin
      rd_ptr_n = rd_ptr + PTR_W'(pop_ok);
      wr_ptr_n = wr_ptr + PTR_W'(push_ok);
      fill_n   = fill + CNT_W'(push_ok) - CNT_W'(pop_ok);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      wr_ptr <= wr_ptr_n;
      rd_ptr <= rd_ptr_n;
      fill   <= fill_n;
    end
  end
endmodule

// File: rtl/rxf_store.sv
module rxf_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [PTR_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [PTR_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/rxf_tags.sv
module rxf_tags
  import rx_fifo_lsr_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [PTR_W-1:0] waddr,
  input  rx_tag_t          wtag,
  input  logic [PTR_W-1:0] head_n,
  output rx_tag_t          head_tag_n
);
  rx_tag_t tags [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)                           tags[i] <= '0;
      else if (we && waddr == PTR_W'(i)) tags[i] <= wtag;
    end
  end

  // The entry that will sit at the head after this edge may be the one
  // being written now; forward it so status needs no extra cycle.
  always_comb begin
    if (we && waddr == head_n) head_tag_n = wtag;
    else                       head_tag_n = tags[head_n];
  end
endmodule

// File: rtl/rxf_status.sv
module rxf_status
  import rx_fifo_lsr_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    head_chg,
  input  logic    lsr_rd,
  input  logic    ovr_hit,
  input  logic    nonempty_n,
  input  rx_tag_t head_tag_n,
  output logic    data_ready,
  output logic    overrun,
  output logic    parity_err,
  output logic    framing_err
);
  logic hide_q;
  logic hide_n;
  logic ovr_n;

  always_comb begin
    if (head_chg)    hide_n = 1'b0;
    else if (lsr_rd) hide_n = 1'b1;
    else             hide_n = hide_q;
    if (ovr_hit)     ovr_n = 1'b1;
    else if (lsr_rd) ovr_n = 1'b0;
    else             ovr_n = overrun;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hide_q      <= 1'b0;
      data_ready  <= 1'b0;
      overrun     <= 1'b0;
      parity_err  <= 1'b0;
      framing_err <= 1'b0;
    end else begin
      hide_q      <= hide_n;
      data_ready  <= nonempty_n;
      overrun     <= ovr_n;
      parity_err  <= nonempty_n && head_tag_n.perr && !hide_n;
      framing_err <= nonempty_n && head_tag_n.ferr && !hide_n;
    end
  end
endmodule

// File: rtl/rx_fifo_lsr.sv
module rx_fifo_lsr
  import rx_fifo_lsr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              char_valid,
  input  logic [DATA_W-1:0] char_data,
  input  logic              char_perr,
  input  logic              char_ferr,
  input  logic              fifo_flush,
  input  logic              rd_data_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic              lsr_rd,
  output logic              data_ready,
  output logic              overrun,
  output logic              parity_err,
  output logic              framing_err
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             push_ok;
  logic             pop_ok;
  logic             head_chg;
  logic             ovr_hit;
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;
  logic [PTR_W-1:0] rd_ptr_n;
  logic [CNT_W-1:0] fill_cnt;
  logic [CNT_W-1:0] fill_n;
  rx_tag_t          in_tag;
  rx_tag_t          head_tag_n;

  assign in_tag = '{perr: char_perr, ferr: char_ferr};

  rxf_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk, .rst,
    .push_req(char_valid), .pop_req(rd_data_en), .flush(fifo_flush),
    .push_ok, .pop_ok, .head_chg, .ovr_hit,
    .wr_ptr, .rd_ptr, .rd_ptr_n,
    .fill(fill_cnt), .fill_n
  );

  rxf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) store_i (
    .clk, .rst,
    .we(push_ok), .waddr(wr_ptr), .wdata(char_data),
    .re(pop_ok), .raddr(rd_ptr), .rdata(rd_data)
  );

  rxf_tags #(.DEPTH(DEPTH)) tags_i (
    .clk, .rst,
    .we(push_ok), .waddr(wr_ptr), .wtag(in_tag),
    .head_n(rd_ptr_n), .head_tag_n
  );

  rxf_status status_i (
    .clk, .rst, .head_chg, .lsr_rd, .ovr_hit,
    .nonempty_n(fill_n != '0), .head_tag_n,
    .data_ready, .overrun, .parity_err, .framing_err
  );
endmodule

// File: rtl/rx_fifo_lsr_chk.sv
module rx_fifo_lsr_chk #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             char_valid,
  input logic             fifo_flush,
  input logic             rd_data_en,
  input logic             lsr_rd,
  input logic             data_ready,
  input logic             overrun,
  input logic             parity_err,
  input logic             framing_err,
  input logic [CNT_W-1:0] fill_cnt
);
  // R4: capacity never exceeded
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
    fill_cnt <= CNT_W'(DEPTH));

  // R4: arrival into a full queue raises overrun next cycle
  p_ovr_on_full_r4: assert property (@(posedge clk) disable iff (rst)
    (char_valid && !fifo_flush && fill_cnt == CNT_W'(DEPTH)) |=> overrun);

  // R2: data_ready only rises after an arrival
  p_dr_rise_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(data_ready) |-> $past(char_valid));

  // R9: empty queue never shows data ready
  p_dr_empty_r9: assert property (@(posedge clk) disable iff (rst)
    data_ready |-> (fill_cnt != '0));

  // R5: error bits only describe an existing head entry
  p_err_has_head_r5: assert property (@(posedge clk) disable iff (rst)
    (parity_err || framing_err) |-> data_ready);

  // R6: a quiet status read clears all error bits
  p_lsr_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (lsr_rd && !char_valid && !rd_data_en && !fifo_flush)
      |=> (!overrun && !parity_err && !framing_err));

  // R8: flush empties the queue
  p_flush_r8: assert property (@(posedge clk) disable iff (rst)
    fifo_flush |=> (!data_ready && !parity_err && !framing_err));
endmodule

bind rx_fifo_lsr rx_fifo_lsr_chk #(.DEPTH(DEPTH)) chk_i (
  .clk, .rst, .char_valid, .fifo_flush, .rd_data_en, .lsr_rd,
  .data_ready, .overrun, .parity_err, .framing_err, .fill_cnt
);

// File: tb/rx_fifo_lsr_tb_top.sv
module rx_fifo_lsr_tb_top;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              char_valid = 1'b0;
  logic [DATA_W-1:0] char_data = '0;
  logic              char_perr = 1'b0;
  logic              char_ferr = 1'b0;
  logic              fifo_flush = 1'b0;
  logic              rd_data_en = 1'b0;
  logic [DATA_W-1:0] rd_data;
  logic              lsr_rd = 1'b0;
  logic              data_ready;
  logic              overrun;
  logic              parity_err;
  logic              framing_err;

  always #4 clk = ~clk;  // 125 MHz

  rx_fifo_lsr #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut_i (
    .clk, .rst, .char_valid, .char_data, .char_perr, .char_ferr,
    .fifo_flush, .rd_data_en, .rd_data, .lsr_rd,
    .data_ready, .overrun, .parity_err, .framing_err
  );

  // ---------------- reference model ----------------
  logic [9:0]        q[$];  // {perr, ferr, data}
  logic              m_hide = 1'b0;
  logic              m_ovr = 1'b0;
  logic [DATA_W-1:0] m_rd = '0;
  int                n_checks = 0;
  int                n_fail = 0;
  int                cycles = 0;
  string             cur_req = "R1";

  always @(posedge clk) begin
    if (rst) begin
      q.delete();
      m_hide = 1'b0;
      m_ovr  = 1'b0;
      m_rd   = '0;
    end else begin
      automatic bit was_full  = (q.size() == DEPTH);
      automatic bit was_empty = (q.size() == 0);
      automatic bit push = char_valid && !fifo_flush && !was_full;
      automatic bit pop  = rd_data_en && !fifo_flush && !was_empty;
      automatic bit lost = char_valid && !fifo_flush && was_full;
      automatic bit moved = fifo_flush || pop || (push && was_empty);
      if (fifo_flush) q.delete();
      if (pop) begin
        automatic logic [9:0] e = q.pop_front();
        m_rd = e[7:0];
      end
      if (push) q.push_back({char_perr, char_ferr, char_data});
      if (moved)       m_hide = 1'b0;
      else if (lsr_rd) m_hide = 1'b1;
      if (lost)        m_ovr = 1'b1;
      else if (lsr_rd) m_ovr = 1'b0;
    end
  end

  task automatic chk1(string what, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h t=%0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    automatic bit ne = (q.size() != 0);
    automatic logic ep = ne && q[0][9] && !m_hide;
    automatic logic ef = ne && q[0][8] && !m_hide;
    chk1("rd_data", rd_data, m_rd);
    chk1("data_ready", {7'b0, data_ready}, {7'b0, ne});
    chk1("overrun", {7'b0, overrun}, {7'b0, m_ovr});
    chk1("parity_err", {7'b0, parity_err}, {7'b0, ep});
    chk1("framing_err", {7'b0, framing_err}, {7'b0, ef});
  endtask

  task automatic step(bit cv, logic [7:0] d, bit pe, bit fe, bit rd, bit ls, bit fl);
    char_valid = cv; char_data = d; char_perr = pe; char_ferr = fe;
    rd_data_en = rd; lsr_rd = ls; fifo_flush = fl;
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 8'h00, 0, 0, 0, 0, 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired act=%0d exp<150000", cycles);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare();  // R1 reset state
    rst = 1'b0;
    idle(2);

    cur_req = "R2";  // writes into empty queue
    for (int i = 0; i < 5; i++) step(1, 8'h10 + 8'(i), 0, 0, 0, 0, 0);
    cur_req = "R3";  // ordered reads, read past empty ignored
    for (int i = 0; i < 7; i++) step(0, 8'h00, 0, 0, 1, 0, 0);
    cur_req = "R9";
    idle(2);

    cur_req = "R5";  // tags behind head stay hidden
    step(1, 8'hA0, 0, 0, 0, 0, 0);
    step(1, 8'hA1, 1, 0, 0, 0, 0);
    step(1, 8'hA2, 0, 1, 0, 0, 0);
    step(1, 8'hA3, 1, 1, 0, 0, 0);
    cur_req = "R7";  // head moves, its tags appear
    for (int i = 0; i < 4; i++) step(0, 8'h00, 0, 0, 1, 0, 0);

    cur_req = "R6";  // status read hides head tag until head changes
    step(1, 8'hB0, 1, 1, 0, 0, 0);
    step(1, 8'hB1, 1, 0, 0, 0, 0);
    step(0, 8'h00, 0, 0, 0, 1, 0);
    idle(2);
    cur_req = "R7";  // read and status read together reveal new head
    step(0, 8'h00, 0, 0, 1, 1, 0);
    step(0, 8'h00, 0, 0, 1, 0, 0);

    cur_req = "R4";  // fill, overflow, with and without same-cycle read
    for (int i = 0; i < DEPTH; i++) step(1, 8'hC0 + 8'(i), i[0], 0, 0, 0, 0);
    step(1, 8'hEE, 1, 1, 0, 0, 0);
    step(1, 8'hEF, 0, 0, 1, 0, 0);
    step(0, 8'h00, 0, 0, 0, 1, 0);
    step(1, 8'hF0, 0, 0, 0, 0, 0);
    step(1, 8'hF1, 0, 0, 0, 1, 0);
    cur_req = "R3";
    for (int i = 0; i < DEPTH + 2; i++) step(0, 8'h00, 0, 0, 1, 0, 0);

    cur_req = "R8";  // flush with same-cycle arrival and read
    for (int i = 0; i < 6; i++) step(1, 8'h30 + 8'(i), 1, 0, 0, 0, 0);
    step(1, 8'h99, 0, 0, 1, 0, 1);
    step(0, 8'h00, 0, 0, 1, 0, 0);
    for (int i = 0; i < DEPTH; i++) step(1, 8'h50 + 8'(i), 0, 0, 0, 0, 0);
    step(1, 8'h77, 0, 0, 0, 0, 0);
    step(0, 8'h00, 0, 0, 0, 0, 1);
    idle(2);

    cur_req = "R9";  // random mix, write-heavy then read-heavy
    for (int ph = 0; ph < 6; ph++) begin
      for (int i = 0; i < 600; i++) begin
        automatic int wp = ph[0] ? 30 : 80;
        automatic int rp = ph[0] ? 80 : 30;
        step(($urandom % 100) < wp, 8'($urandom), ($urandom % 4) == 0,
             ($urandom % 4) == 0, ($urandom % 100) < rp,
             ($urandom % 8) == 0, ($urandom % 97) == 0);
      end
    end

    cur_req = "R1";  // reset mid-traffic
    for (int i = 0; i < 4; i++) step(1, 8'h44, 1, 1, 0, 0, 0);
    rst = 1'b1;
    step(0, 8'h00, 0, 0, 0, 0, 0);
    rst = 1'b0;
    idle(2);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule